// File: doc/BRIEF.md
# Memory-Mapped Vectored Interrupt Controller

This block collects up to 32 interrupt request lines and presents them to a processor as one interrupt output. The processor reaches the block through a plain 32-bit register bus with an address, write data, a write strobe, a read strobe and combinational read data. Requests are captured into a sticky status register. An enable mask filters the status into a pending set. The output is raised when the pending set is non-empty and the output is enabled. A vector register names the lowest-numbered pending source, so the interrupt handler needs no scan loop.

Software changes single enable bits through two alias registers. One sets mask bits and the other clears them, so no read-modify-write is needed. A service routine clears captured requests by writing ones to an acknowledge register. A two-bit master control switches the output on and separately lets hardware requests into the status register. While hardware capture is off, software can set status bits itself to exercise the handler. Every source is handled the same way: a request that is still high after it is acknowledged is captured again.

Top module: `vec_intc`

## Requirements
- R1: After reset the status, enable and master registers read zero, the interrupt output is low and the vector (byte offset 24) reads 0xFFFFFFFF.
- R2: While master bit 1 is set, a high request line n sets status bit n (byte offset 0) at the next clock edge. The bit stays set after the line drops.
- R3: While master bit 1 is clear, request lines have no effect on status, and a write to offset 0 sets the status bits where the data has ones. While master bit 1 is set, a write to offset 0 has no effect.
- R4: A write to offset 8 replaces the enable mask. A write to offset 16 sets the mask bits where the data has ones. A write to offset 20 clears the mask bits where the data has ones. In each case the other mask bits are unchanged.
- R5: Offset 4 reads status AND enable.
- R6: Writing ones to offset 12 clears those status bits. If that request line is high in the same cycle while master bit 1 is set, the bit stays set.
- R7: The interrupt output is high exactly when master bit 0 is set and at least one pending bit is set. It follows a register write from the next cycle.
- R8: Offset 24 reads the index of the lowest-numbered pending source, zero-extended, or 0xFFFFFFFF when nothing is pending. When several sources become pending together, the lower index is reported.
- R9: Offsets 12, 16 and 20 read zero. Offset 28 reads the master bits in bits 1:0 with zeros above. Read data is zero while the read strobe is low.
- R10: Address bits 1:0 are ignored, so any byte address within a word selects that word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irqIn | input | NUM_SRC | Request lines, bit n is source n |
| busAddr | input | 5 | Byte address within the 32-byte window |
| busWdata | input | 32 | Write data |
| busWe | input | 1 | Write strobe, one cycle per write |
| busRe | input | 1 | Read strobe |
| busRdata | output | 32 | Combinational read data |
| irqOut | output | 1 | Interrupt to the processor |

## Verification
A wrong status bit shows up at the pending register and the vector in the very next read. It also shows at the interrupt output one cycle after the bad capture or acknowledge. A corrupt enable mask shows at the same points, and also as a mismatch on a direct read of offset 8. A master bit stuck at the wrong value shows either as an interrupt raised while the output is off, or as requests captured while capture is supposed to be off. Each of these is visible at a port within one or two cycles of the stimulus that caused it.

// File: rtl/vec_intc_pkg.sv
package vec_intc_pkg;
  localparam int DATA_W = 32;
  localparam int ADDR_W = 5;
  localparam int SLOT_W = 3;

  localparam logic [SLOT_W-1:0] SLOT_STATUS = 3'd0;
  localparam logic [SLOT_W-1:0] SLOT_PEND   = 3'd1;
  localparam logic [SLOT_W-1:0] SLOT_MASK   = 3'd2;
  localparam logic [SLOT_W-1:0] SLOT_ACK    = 3'd3;
  localparam logic [SLOT_W-1:0] SLOT_SETEN  = 3'd4;
  localparam logic [SLOT_W-1:0] SLOT_CLREN  = 3'd5;
  localparam logic [SLOT_W-1:0] SLOT_VECTOR = 3'd6;
  localparam logic [SLOT_W-1:0] SLOT_MASTER = 3'd7;

  typedef struct packed {
    logic wrStatus;
    logic wrMask;
    logic wrAck;
    logic wrSetEn;
    logic wrClrEn;
    logic wrMaster;
    logic rdEn;
    logic [SLOT_W-1:0] rdSlot;
  } strobe_t;
endpackage

// File: rtl/vec_intc_ctrl.sv
module vec_intc_ctrl
  import vec_intc_pkg::*;
(
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  input  logic              busRe,
  output strobe_t           strobe
);
  logic [SLOT_W-1:0] slot;

  // byte lanes ignored: word slot is taken from the upper address bits
  assign slot = busAddr[ADDR_W-1:2];

  always_comb begin
    strobe          = '0;
    strobe.rdEn     = busRe;
    strobe.rdSlot   = slot;
    strobe.wrStatus = busWe && (slot == SLOT_STATUS);
    strobe.wrMask   = busWe && (slot == SLOT_MASK);
    strobe.wrAck    = busWe && (slot == SLOT_ACK);
    strobe.wrSetEn  = busWe && (slot == SLOT_SETEN);
    strobe.wrClrEn  = busWe && (slot == SLOT_CLREN);
    strobe.wrMaster = busWe && (slot == SLOT_MASTER);
  end
endmodule

// File: rtl/vec_intc_lowfind.sv
module vec_intc_lowfind #(
  parameter int NUM_SRC = 32,
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] pendVec,
  output logic               anyPend,
  output logic [IDX_W-1:0]   lowIdx
);
  logic [NUM_SRC-1:0] lowOnly;
  logic [IDX_W-1:0]   term [NUM_SRC];

  // isolate the lowest set bit, then OR together the index of that one bit
  assign lowOnly = pendVec & (~pendVec + 1'b1);
  assign anyPend = |pendVec;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_term
    assign term[i] = lowOnly[i] ? IDX_W'(i) : '0;
  end

  always_comb begin
    lowIdx = '0;
    for (int i = 0; i < NUM_SRC; i++) lowIdx = lowIdx | term[i];
  end
endmodule

// File: rtl/vec_intc_dp.sv
module vec_intc_dp
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  strobe_t            strobe,
  input  logic [DATA_W-1:0]  busWdata,
  input  logic [NUM_SRC-1:0] irqIn,
  output logic [DATA_W-1:0]  busRdata,
  output logic               irqOut,
  output logic [NUM_SRC-1:0] statusQ,
  output logic [NUM_SRC-1:0] maskQ,
  output logic [1:0]         masterQ,
  output logic [DATA_W-1:0]  vectorVal
);
  localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic [NUM_SRC-1:0] wdSrc;
  logic [NUM_SRC-1:0] pendVec;
  logic [NUM_SRC-1:0] hwSet, swSet, ackClr;
  logic [IDX_W-1:0]   lowIdx;
  logic               anyPend;
  logic               hwCapture, outEnable;

  assign wdSrc     = busWdata[NUM_SRC-1:0];
  assign outEnable = masterQ[0];
  assign hwCapture = masterQ[1];
  assign hwSet     = hwCapture ? irqIn : '0;
  assign swSet     = (strobe.wrStatus && !hwCapture) ? wdSrc : '0;
  assign ackClr    = strobe.wrAck ? wdSrc : '0;

  // clear first, then set: a line still high after acknowledge is recaptured
  always_ff @(posedge clk) begin
    if (rst) statusQ <= '0;
    else     statusQ <= (statusQ & ~ackClr) | hwSet | swSet;
  end

  always_ff @(posedge clk) begin
    if (rst)                 maskQ <= '0;
    else if (strobe.wrMask)  maskQ <= wdSrc;
    else if (strobe.wrSetEn) maskQ <= maskQ | wdSrc;
    else if (strobe.wrClrEn) maskQ <= maskQ & ~wdSrc;
  end

  always_ff @(posedge clk) begin
    if (rst)                  masterQ <= '0;
    else if (strobe.wrMaster) masterQ <= busWdata[1:0];
  end

  assign pendVec = statusQ & maskQ;

  vec_intc_lowfind #(.NUM_SRC(NUM_SRC)) u_lowfind (
    .pendVec (pendVec),
    .anyPend (anyPend),
    .lowIdx  (lowIdx)
  );

  assign vectorVal = anyPend ? DATA_W'(lowIdx) : '1;
  assign irqOut    = outEnable && anyPend;

  always_comb begin
    busRdata = '0;
    if (strobe.rdEn) begin
      unique case (strobe.rdSlot)
        SLOT_STATUS: busRdata = DATA_W'(statusQ);
        SLOT_PEND:   busRdata = DATA_W'(pendVec);
        SLOT_MASK:   busRdata = DATA_W'(maskQ);
        SLOT_VECTOR: busRdata = vectorVal;
        SLOT_MASTER: busRdata = DATA_W'(masterQ);
        default:     busRdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/vec_intc.sv
module vec_intc
  import vec_intc_pkg::*;
#(
  parameter int NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] irqIn,
  input  logic [4:0]         busAddr,
  input  logic [31:0]        busWdata,
  input  logic               busWe,
  input  logic               busRe,
  output logic [31:0]        busRdata,
  output logic               irqOut
);
  strobe_t            strobe;
  logic [NUM_SRC-1:0] statusQ, maskQ;
  logic [1:0]         masterQ;
  logic [DATA_W-1:0]  vectorVal;

  vec_intc_ctrl u_ctrl (
    .busAddr (busAddr),
    .busWe   (busWe),
    .busRe   (busRe),
    .strobe  (strobe)
  );

  vec_intc_dp #(.NUM_SRC(NUM_SRC)) u_dp (
    .clk       (clk),
    .rst       (rst),
    .strobe    (strobe),
    .busWdata  (busWdata),
    .irqIn     (irqIn),
    .busRdata  (busRdata),
    .irqOut    (irqOut),
    .statusQ   (statusQ),
    .maskQ     (maskQ),
    .masterQ   (masterQ),
    .vectorVal (vectorVal)
  );
endmodule

// File: rtl/vec_intc_chk.sv
module vec_intc_chk #(
  parameter int NUM_SRC = 32
) (
  input logic               clk,
  input logic               rst,
  input logic [NUM_SRC-1:0] irqIn,
  input logic [4:0]         busAddr,
  input logic [31:0]        busWdata,
  input logic               busWe,
  input logic               irqOut,
  input logic [NUM_SRC-1:0] statusQ,
  input logic [NUM_SRC-1:0] maskQ,
  input logic [1:0]         masterQ,
  input logic [31:0]        vectorVal
);
  logic statusWr, setEnWr, clrEnWr;
  assign statusWr = busWe && (busAddr[4:2] == 3'd0);
  assign setEnWr  = busWe && (busAddr[4:2] == 3'd4);
  assign clrEnWr  = busWe && (busAddr[4:2] == 3'd5);

  AST_HW_CAPTURE: assert property (@(posedge clk) disable iff (rst)
    masterQ[1] |=> ((statusQ & $past(irqIn)) == $past(irqIn))); // R2

  AST_NO_SPURIOUS_SET: assert property (@(posedge clk) disable iff (rst)
    (!masterQ[1] && !statusWr) |=> ((statusQ & ~$past(statusQ)) == '0)); // R3

  AST_SETEN_ALIAS: assert property (@(posedge clk) disable iff (rst)
    setEnWr |=> ((maskQ & $past(busWdata[NUM_SRC-1:0])) == $past(busWdata[NUM_SRC-1:0]))); // R4

  AST_CLREN_ALIAS: assert property (@(posedge clk) disable iff (rst)
    clrEnWr |=> ((maskQ & $past(busWdata[NUM_SRC-1:0])) == '0)); // R4

  AST_OUT_GATED: assert property (@(posedge clk) disable iff (rst)
    !masterQ[0] |-> !irqOut); // R7

  AST_IDLE_VECTOR: assert property (@(posedge clk) disable iff (rst)
    ((statusQ & maskQ) == '0) |-> (vectorVal == 32'hFFFF_FFFF)); // R8
endmodule

bind vec_intc vec_intc_chk #(.NUM_SRC(NUM_SRC)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .irqIn     (irqIn),
  .busAddr   (busAddr),
  .busWdata  (busWdata),
  .busWe     (busWe),
  .irqOut    (irqOut),
  .statusQ   (statusQ),
  .maskQ     (maskQ),
  .masterQ   (masterQ),
  .vectorVal (vectorVal)
);

// File: tb/sim_vec_intc.sv
module sim_vec_intc;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] irqIn = '0;
  logic [4:0]  busAddr = '0;
  logic [31:0] busWdata = '0;
  logic        busWe = 1'b0;
  logic        busRe = 1'b0;
  logic [31:0] busRdata;
  logic        irqOut;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  vec_intc #(.NUM_SRC(32)) u0 (
    .clk(clk), .rst(rst), .irqIn(irqIn), .busAddr(busAddr),
    .busWdata(busWdata), .busWe(busWe), .busRe(busRe),
    .busRdata(busRdata), .irqOut(irqOut)
  );

  // entry: {op, req, addr, wdata, irq, expRead, expIrq}; op 0 idle, 1 write, 2 read
  localparam int NV = 45;
  localparam logic [139:0] VEC [NV] = '{
    {2'd2, 4'd1,  5'd0,  32'h0, 32'h0, 32'h0, 1'b0},                 // R1 status zero
    {2'd2, 4'd1,  5'd24, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0},         // R1 vector idle
    {2'd1, 4'd2,  5'd28, 32'h3, 32'h0, 32'h0, 1'b0},
    {2'd0, 4'd2,  5'd0,  32'h0, 32'h24, 32'h0, 1'b0},
    {2'd2, 4'd2,  5'd0,  32'h0, 32'h0, 32'h24, 1'b0},                // R2 latched
    {2'd2, 4'd5,  5'd4,  32'h0, 32'h0, 32'h0, 1'b0},                 // R5
    {2'd1, 4'd4,  5'd16, 32'h30, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd4,  5'd8,  32'h0, 32'h0, 32'h30, 1'b1},                // R4 set alias
    {2'd2, 4'd5,  5'd4,  32'h0, 32'h0, 32'h20, 1'b1},                // R5 R7
    {2'd2, 4'd8,  5'd24, 32'h0, 32'h0, 32'h5, 1'b1},                 // R8
    {2'd1, 4'd4,  5'd16, 32'h4, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd8,  5'd24, 32'h0, 32'h0, 32'h2, 1'b1},                 // R8 lowest wins
    {2'd1, 4'd4,  5'd20, 32'h10, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd4,  5'd8,  32'h0, 32'h0, 32'h24, 1'b1},                // R4 clear alias
    {2'd1, 4'd6,  5'd12, 32'h4, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd6,  5'd0,  32'h0, 32'h0, 32'h20, 1'b1},                // R6 ack
    {2'd2, 4'd8,  5'd24, 32'h0, 32'h0, 32'h5, 1'b1},                 // R8
    {2'd1, 4'd6,  5'd12, 32'h20, 32'h20, 32'h0, 1'b0},
    {2'd2, 4'd6,  5'd0,  32'h0, 32'h0, 32'h20, 1'b1},                // R6 recapture
    {2'd1, 4'd6,  5'd12, 32'hFFFF_FFFF, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd6,  5'd0,  32'h0, 32'h0, 32'h0, 1'b0},                 // R6 ack all
    {2'd2, 4'd8,  5'd24, 32'h0, 32'h0, 32'hFFFF_FFFF, 1'b0},         // R8 none
    {2'd2, 4'd9,  5'd12, 32'h0, 32'h0, 32'h0, 1'b0},                 // R9
    {2'd2, 4'd9,  5'd16, 32'h0, 32'h0, 32'h0, 1'b0},                 // R9
    {2'd2, 4'd9,  5'd20, 32'h0, 32'h0, 32'h0, 1'b0},                 // R9
    {2'd2, 4'd9,  5'd28, 32'h0, 32'h0, 32'h3, 1'b0},                 // R9
    {2'd1, 4'd7,  5'd28, 32'h2, 32'h1, 32'h0, 1'b0},
    {2'd1, 4'd7,  5'd16, 32'h1, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd7,  5'd4,  32'h0, 32'h0, 32'h1, 1'b0},                 // R7 output off
    {2'd1, 4'd3,  5'd28, 32'h0, 32'h0, 32'h0, 1'b0},
    {2'd0, 4'd3,  5'd0,  32'h0, 32'h80, 32'h0, 1'b0},
    {2'd2, 4'd3,  5'd0,  32'h0, 32'h0, 32'h1, 1'b0},                 // R3 lines ignored
    {2'd1, 4'd3,  5'd0,  32'h100, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd3,  5'd0,  32'h0, 32'h0, 32'h101, 1'b0},               // R3 sw set
    {2'd1, 4'd3,  5'd28, 32'h3, 32'h0, 32'h0, 1'b0},
    {2'd1, 4'd3,  5'd0,  32'h200, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd3,  5'd0,  32'h0, 32'h0, 32'h101, 1'b1},               // R3 sw write ignored
    {2'd1, 4'd4,  5'd8,  32'h0, 32'h0, 32'h0, 1'b0},
    {2'd2, 4'd4,  5'd8,  32'h0, 32'h0, 32'h0, 1'b0},                 // R4 replace
    {2'd1, 4'd4,  5'd8,  32'h8000_0000, 32'h0, 32'h0, 1'b0},
    {2'd0, 4'd2,  5'd0,  32'h0, 32'h8000_0000, 32'h0, 1'b0},
    {2'd2, 4'd8,  5'd24, 32'h0, 32'h0, 32'h1F, 1'b1},                // R8 top source
    {2'd2, 4'd10, 5'd25, 32'h0, 32'h0, 32'h1F, 1'b1},                // R10 byte lane
    {2'd2, 4'd10, 5'd7,  32'h0, 32'h0, 32'h8000_0000, 1'b1},         // R10 pending via 7
    {2'd2, 4'd5,  5'd4,  32'h0, 32'h0, 32'h8000_0000, 1'b1}          // R5
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic busWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic busReadCheck(input logic [4:0] a, input logic [31:0] exp, input string tag);
    @(negedge clk);
    busAddr = a; busRe = 1'b1;
    #1 check(tag, busRdata, exp);
    busRe = 1'b0;
  endtask

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 irqOut after reset", {31'b0, irqOut}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [1:0]  op;
      logic [3:0]  rq;
      logic [4:0]  ad;
      logic [31:0] wd, iq, ex;
      logic        ei;
      string       tag;
      {op, rq, ad, wd, iq, ex, ei} = VEC[i];
      @(negedge clk);
      irqIn = iq; busAddr = ad; busWdata = wd;
      busWe = (op == 2'd1);
      busRe = (op == 2'd2);
      if (op == 2'd2) begin
        #1;
        tag = $sformatf("R%0d read step %0d", rq, i);
        check(tag, busRdata, ex);
        tag = $sformatf("R7 irqOut step %0d (R%0d)", i, rq);
        check(tag, {31'b0, irqOut}, {31'b0, ei});
      end
      @(posedge clk);
      #1 busWe = 1'b0; busRe = 1'b0;
    end
    @(negedge clk);
    irqIn = '0;

    // R9: no read strobe gives zero read data
    @(negedge clk);
    busAddr = 5'd24; busRe = 1'b0;
    #1 check("R9 rdata without strobe", busRdata, 32'h0);

    // R8: two sources arriving together, lower index reported
    busWrite(5'd12, 32'hFFFF_FFFF);
    busWrite(5'd8, 32'hFFFF_FFFF);
    @(negedge clk);
    irqIn = 32'h0001_8000;
    @(negedge clk);
    irqIn = '0;
    busReadCheck(5'd24, 32'hF, "R8 simultaneous pair");
    #1 check("R7 irqOut with pair pending", {31'b0, irqOut}, 32'h1);

    // R7: output follows master bit 0 from the cycle after the write
    busWrite(5'd28, 32'h2);
    #1 check("R7 irqOut master off", {31'b0, irqOut}, 32'h0);

    // R1: reset in the middle of activity
    busWrite(5'd28, 32'h3);
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    #1 check("R1 irqOut after mid reset", {31'b0, irqOut}, 32'h0);
    busReadCheck(5'd0, 32'h0, "R1 status after reset");
    busReadCheck(5'd8, 32'h0, "R1 enable after reset");
    busReadCheck(5'd28, 32'h0, "R1 master after reset");
    busReadCheck(5'd24, 32'hFFFF_FFFF, "R1 vector after reset");

    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule